// File: doc/BRIEF.md
# Prioritized Acknowledge Interrupt Controller

This block gathers interrupt requests from five sources into an eight-bit pending register and drives a single interrupt line toward a host processor. The line is high whenever any pending bit is set. Two sources, a real-time clock and a serial port, are set and cleared by their own strobes. They raise the interrupt line but never receive a vector. A signal-processor mailbox and a frame-blank tick are edge-type sources: one strobe each sets the bit. The disk controller is level-type: its bit follows the controller's request line.

When the host acknowledges, the block picks the highest-priority pending vectored source and returns its vector. The order is disk, then signal processor, then frame blank. The acknowledge clears the winning bit when the winner is an edge-type source. It leaves the disk bit alone, because only the controller's own line can drop it. An acknowledge with no vectored source pending returns vector 0 and sets a sticky error flag.

The vector leaves on a valid/ready-style stream with no ready input. `ack_vld` is a one-cycle pulse that the host must capture, since there is no back-pressure. Every `ack_req` produces exactly one pulse, one cycle later. Back-to-back acknowledges are allowed.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The pending register `irq_status` holds the real-time clock at bit 1, the serial port at bit 2, the signal processor at bit 4, frame blank at bit 5 and disk at bit 7. Bits 0, 3 and 6 always read 0. A set takes effect on `irq_status` one cycle after the strobe.
- R2: `irq` is 1 exactly when `irq_status` is non-zero.
- R3: On an acknowledge, the winner is chosen from the pending bits before the edge. Disk beats signal processor, and signal processor beats frame blank.
- R4: One cycle after `ack_req`, `ack_vld` pulses for one cycle. `ack_vec` is then 11 for disk, 12 for signal processor, 13 for frame blank and 0 for no winner.
- R5: An acknowledge clears the signal-processor or frame-blank bit only when that source is the winner. All other bits are unchanged by it.
- R6: Bit 7 equals `disk_level` as sampled at the previous edge, whether or not an acknowledge occurs.
- R7: An acknowledge with bits 7, 4 and 5 all clear returns vector 0 and sets `err`. `err` stays set until reset, even when only bits 1 or 2 are pending.
- R8: When a set strobe and an acknowledge-clear hit the same bit in the same cycle, the bit stays set. The vector is still returned.
- R9: `rtc_set`/`rtc_clr` and `uart_set`/`uart_clr` set and clear bits 1 and 2. Set wins over clear in the same cycle.
- R10: During reset `irq_status`, `irq`, `ack_vld`, `ack_vec` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_set | input | 1 | Set real-time clock request |
| rtc_clr | input | 1 | Clear real-time clock request |
| uart_set | input | 1 | Set serial port request |
| uart_clr | input | 1 | Clear serial port request |
| dsp_set | input | 1 | Signal-processor mailbox write strobe |
| vblank_set | input | 1 | Once-per-frame blank strobe |
| disk_level | input | 1 | Disk controller request level |
| ack_req | input | 1 | Host acknowledge strobe |
| ack_vld | output | 1 | Vector valid pulse |
| ack_vec | output | 8 | Returned vector |
| irq | output | 1 | Interrupt line to host |
| irq_status | output | 8 | Pending register |
| err | output | 1 | Sticky empty-acknowledge error |

## Verification
Two functions can land in the same cycle: an acknowledge-clear of the winning edge bit, and a fresh set strobe for that bit. The bench provokes this directly by raising `dsp_set` in the same cycle as `ack_req` while the signal processor is the winner. It then expects vector 12 with the bit still pending. In a long random phase, set, clear, level changes and acknowledges also collide freely. A behavioural model tracks all of them and is compared against every output at each clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int STAT_W   = 8;
  localparam int VEC_W    = 8;
  localparam int RTC_BIT  = 1;
  localparam int UART_BIT = 2;
  localparam int DSP_BIT  = 4;
  localparam int VBL_BIT  = 5;
  localparam int DISK_BIT = 7;
  localparam int VEC_DISK = 11;
  localparam int VEC_DSP  = 12;
  localparam int VEC_VBL  = 13;
  localparam int VEC_NONE = 0;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DISK = 2'd1,
    WIN_DSP  = 2'd2,
    WIN_VBL  = 2'd3
  } win_e;
endpackage

// File: rtl/pic_latch_bit.sv
module pic_latch_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R8 / R9: a set always lands, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clr_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  output win_e              win_o,
  output logic [VEC_W-1:0]  vec_o
);
  always_comb begin
    if (status_i[DISK_BIT]) begin
      win_o = WIN_DISK;
      vec_o = VEC_W'(VEC_DISK);
    end else if (status_i[DSP_BIT]) begin
      win_o = WIN_DSP;
      vec_o = VEC_W'(VEC_DSP);
    end else if (status_i[VBL_BIT]) begin
      win_o = WIN_VBL;
      vec_o = VEC_W'(VEC_VBL);
    end else begin
      win_o = WIN_NONE;
      vec_o = VEC_W'(VEC_NONE);
    end
  end

  // R3: a lower source never wins over a pending higher one
  always_comb begin
    if (win_o == WIN_VBL)
      p_vbl_lowest_r3: assert (!status_i[DISK_BIT] && !status_i[DSP_BIT]);
    if (win_o == WIN_DSP)
      p_dsp_below_disk_r3: assert (!status_i[DISK_BIT]);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_set,
  input  logic              rtc_clr,
  input  logic              uart_set,
  input  logic              uart_clr,
  input  logic              dsp_set,
  input  logic              vblank_set,
  input  logic              disk_level,
  input  logic              ack_req,
  output logic              ack_vld,
  output logic [VEC_W-1:0]  ack_vec,
  output logic              irq,
  output logic [STAT_W-1:0] irq_status,
  output logic              err
);
  localparam int NLAT = 4;
  localparam int LAT_POS [NLAT] = '{RTC_BIT, UART_BIT, DSP_BIT, VBL_BIT};

  logic [NLAT-1:0] lat_set, lat_clr, lat_q;
  logic            disk_q;
  win_e            win;
  logic [VEC_W-1:0] vec_c;

  assign lat_set = {vblank_set, dsp_set, uart_set, rtc_set};
  assign lat_clr = {ack_req && (win == WIN_VBL),
                    ack_req && (win == WIN_DSP),
                    uart_clr, rtc_clr};

  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    pic_latch_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (lat_set[g]),
      .clr_i (lat_clr[g]),
      .q_o   (lat_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) disk_q <= 1'b0;
    else        disk_q <= disk_level;
  end

  always_comb begin
    irq_status = '0;
    for (int i = 0; i < NLAT; i++) irq_status[LAT_POS[i]] = lat_q[i];
    irq_status[DISK_BIT] = disk_q;
  end

  assign irq = |irq_status;

  pic_prio u_prio (
    .status_i (irq_status),
    .win_o    (win),
    .vec_o    (vec_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack_vec <= '0;
      err     <= 1'b0;
    end else begin
      ack_vld <= ack_req;
      if (ack_req) ack_vec <= vec_c;
      if (ack_req && win == WIN_NONE) err <= 1'b1;
    end
  end

  // R6: disk bit follows the level, ack or not
  p_disk_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disk_level |=> irq_status[DISK_BIT]);
  p_disk_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !disk_level |=> !irq_status[DISK_BIT]);
  // R4: one pulse per acknowledge
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_vld);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_vld);
  // R5: winning edge source is cleared
  p_dsp_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && irq_status[DSP_BIT] && !irq_status[DISK_BIT] && !dsp_set)
      |=> !irq_status[DSP_BIT]);
  // R7: sticky error
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rtc_set = 0, rtc_clr = 0, uart_set = 0, uart_clr = 0;
  logic dsp_set = 0, vblank_set = 0, disk_level = 0, ack_req = 0;
  logic       ack_vld, irq, err;
  logic [7:0] ack_vec, irq_status;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rtc_set(rtc_set), .rtc_clr(rtc_clr),
    .uart_set(uart_set), .uart_clr(uart_clr),
    .dsp_set(dsp_set), .vblank_set(vblank_set),
    .disk_level(disk_level), .ack_req(ack_req),
    .ack_vld(ack_vld), .ack_vec(ack_vec), .irq(irq),
    .irq_status(irq_status), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_rtc, m_uart, m_dsp, m_vbl, m_disk, m_vld, m_err;
  int m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rtc = 0; m_uart = 0; m_dsp = 0; m_vbl = 0; m_disk = 0;
      m_vld = 0; m_err = 0; m_vec = 0;
    end else begin
      int who;
      who = m_disk ? 11 : m_dsp ? 12 : m_vbl ? 13 : 0;
      m_vld = ack_req;
      if (ack_req) begin
        m_vec = who;
        if (who == 0) m_err = 1;
        if (who == 12) m_dsp = 0;
        if (who == 13) m_vbl = 0;
      end
      if (dsp_set) m_dsp = 1;
      if (vblank_set) m_vbl = 1;
      if (rtc_set) m_rtc = 1; else if (rtc_clr) m_rtc = 0;
      if (uart_set) m_uart = 1; else if (uart_clr) m_uart = 0;
      m_disk = disk_level;
    end
  end

  function automatic int m_stat();
    return (int'(m_disk) << 7) | (int'(m_vbl) << 5) | (int'(m_dsp) << 4) |
           (int'(m_uart) << 2) | (int'(m_rtc) << 1);
  endfunction

  always @(negedge clk) if (!done) begin
    check("R1 status", irq_status, m_stat());
    check("R2 irq", irq, m_stat() != 0);
    check("R4 valid", ack_vld, m_vld);
    if (m_vld) check("R4 vector", ack_vec, m_vec);
    check("R7 err", err, m_err);
  end

  task automatic idle();
    rtc_set = 0; rtc_clr = 0; uart_set = 0; uart_clr = 0;
    dsp_set = 0; vblank_set = 0; ack_req = 0;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; idle(); disk_level = 0;
    step(); step();
    check("R10 status", irq_status, 0);
    check("R10 irq", irq, 0);
    check("R10 vld", ack_vld, 0);
    check("R10 vec", ack_vec, 0);
    check("R10 err", err, 0);
    rst_n = 1;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1/R2: dsp and vblank strobes
    dsp_set = 1; vblank_set = 1; step(); idle();
    check("R1 dsp bit", irq_status[4], 1);
    check("R1 vblank bit", irq_status[5], 1);
    check("R2 irq high", irq, 1);
    // R3/R5: dsp wins, only dsp cleared
    ack_req = 1; step(); idle();
    check("R3 dsp over vblank", ack_vec, 12);
    check("R5 dsp cleared", irq_status[4], 0);
    check("R5 vblank kept", irq_status[5], 1);
    ack_req = 1; step(); idle();
    check("R4 vblank vector", ack_vec, 13);
    check("R2 irq low", irq, 0);
    // R7: empty ack
    ack_req = 1; step(); idle();
    check("R7 empty vector", ack_vec, 0);
    check("R7 err set", err, 1);
    step(); step();
    check("R7 err sticky", err, 1);
    do_reset();
    // R6/R3: disk wins and stays
    disk_level = 1; dsp_set = 1; step(); idle();
    ack_req = 1; step(); idle();
    check("R3 disk first", ack_vec, 11);
    check("R6 disk stays", irq_status[7], 1);
    check("R5 dsp untouched", irq_status[4], 1);
    disk_level = 0; step();
    check("R6 disk drops", irq_status[7], 0);
    // R8: set collides with ack-clear
    ack_req = 1; dsp_set = 1; step(); idle();
    check("R8 vector", ack_vec, 12);
    check("R8 set wins", irq_status[4], 1);
    ack_req = 1; step(); idle();
    // R9: rtc set/clear, set wins
    rtc_set = 1; rtc_clr = 1; step(); idle();
    check("R9 set wins", irq_status[1], 1);
    uart_set = 1; step(); idle();
    check("R9 uart bit", irq_status[2], 1);
    ack_req = 1; step(); idle();
    check("R7 rtc/uart not vectored", ack_vec, 0);
    check("R7 err from unvectored", err, 1);
    check("R9 rtc kept after ack", irq_status[1], 1);
    rtc_clr = 1; uart_clr = 1; step(); idle();
    check("R9 cleared", irq_status & 8'h06, 0);
    // random collisions
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      rtc_set = ($urandom % 8) == 0; rtc_clr = ($urandom % 8) == 0;
      uart_set = ($urandom % 8) == 0; uart_clr = ($urandom % 8) == 0;
      dsp_set = ($urandom % 5) == 0; vblank_set = ($urandom % 6) == 0;
      if (($urandom % 10) == 0) disk_level = ~disk_level;
      ack_req = ($urandom % 3) == 0;
      if (i == 1500) begin
        idle(); do_reset();
      end else step();
    end
    idle(); step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule